// File: doc/BRIEF.md
# Single-Slot Elastic Pipeline Register

This block is one stage of an elastic pipeline. It holds at most one data word between an upstream producer and a downstream consumer. Both sides use a ready/valid handshake, and a word moves across a side on a rising clock edge where ready and valid are both high.

The upstream ready is a combinational function of the downstream ready. A stage that is full but being emptied in the same cycle therefore still takes a new word. This lets a chain of these stages carry one word per clock with no bubbles. The cost is a combinational path from the downstream ready back to the upstream ready.

Two parameters shape the data register:
- `CLEAR_DATA` decides whether reset zeroes the data register.
- `GATE_LOAD` decides whether the register loads only on an accepted handshake, or on every cycle in which the stage can accept.

Top module: `elastic_stage`

## Requirements
- R1: `ready_o` is high whenever `valid_o` is low or `ready_i` is high. It is low only when the stage is full and `ready_i` is low. This is combinational within the same cycle.
- R2: A rising clock edge with `rst_i` high leaves `valid_o` low, for any parameter setting.
- R3: On an edge where `valid_i` and `ready_o` are both high, the stage becomes full. After that edge `valid_o` is 1 and `data_o` equals the `data_i` that was presented.
- R4: While `valid_o` is 1 and `ready_i` is 0, the stage keeps `valid_o` at 1 and `data_o` unchanged.
- R5: On an edge where the word is taken (`valid_o` and `ready_i` high) and `valid_i` is low, `valid_o` becomes 0.
- R6: On an edge where the word is taken and a new word is accepted, `valid_o` stays 1 and `data_o` takes the new word. This gives one transfer per clock.
- R7: With `CLEAR_DATA`=1, `data_o` is 0 after a rising edge with `rst_i` high.
- R8: With `CLEAR_DATA`=0, a reset edge on which no load is enabled leaves `data_o` unchanged.
- R9: With `GATE_LOAD`=1, an edge with `ready_o` high and `valid_i` low leaves `data_o` unchanged.
- R10: With `GATE_LOAD`=0, every edge with `ready_o` high loads `data_i` into `data_o`, whatever `valid_i` is.
- R11: While full and `ready_i` is low, an offered word (`valid_i`=1) is not accepted and does not change `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Upstream word present |
| data_i | input | WIDTH | Upstream word |
| ready_o | output | 1 | Stage can accept a word this cycle |
| valid_o | output | 1 | Stage holds a word |
| data_o | output | WIDTH | Held word |
| ready_i | input | 1 | Downstream takes the word this cycle |

## Verification
The properties assume that `valid_i`, `data_i` and `ready_i` are settled well before each rising edge, and that `ready_i` does not depend combinationally on `valid_o` in a way that forms a loop.

The bench drives all inputs one time unit after each rising edge and samples both outputs at that same point. The combinational ready path is settled before it is read.

Because the two parameterizations run on shared stimulus, every sequence is legal for both instances. The sequence also keeps the no-clear instance full with a stalled consumer across its reset edge, so R8 is seen at the port.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_e;

endpackage

// File: rtl/elastic_hs_ctl.sv
module elastic_hs_ctl
  import elastic_pkg::*;
#(
  parameter bit GATE_LOAD = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic valid_i,
  input  logic ready_i,
  output logic ready_o,
  output logic full_o,
  output logic load_o
);

  slot_e slot_q;
  slot_e slot_d;

  // Upstream may push when the slot is free or being drained now.
  assign ready_o = (slot_q == SLOT_EMPTY) || ready_i;
  assign full_o  = (slot_q == SLOT_FULL);

  always_comb begin
    slot_d = slot_q;
    if (ready_o) begin
      slot_d = valid_i ? SLOT_FULL : SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slot_q <= SLOT_EMPTY;
    end else begin
      slot_q <= slot_d;
    end
  end

  generate
    if (GATE_LOAD) begin : g_gated
      assign load_o = ready_o && valid_i;
    end else begin : g_free
      assign load_o = ready_o;
    end
  endgenerate

endmodule

// File: rtl/elastic_dreg.sv
module elastic_dreg #(
  parameter int WIDTH      = 8,
  parameter bit CLEAR_DATA = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_r;

  generate
    if (CLEAR_DATA) begin : g_clear
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          q_r <= '0;
        end else if (load_i) begin
          q_r <= d_i;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk_i) begin
        if (load_i) begin
          q_r <= d_i;
        end
      end
    end
  endgenerate

  assign q_o = q_r;

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage #(
  parameter int WIDTH      = 8,
  parameter bit CLEAR_DATA = 1'b1,
  parameter bit GATE_LOAD  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  input  logic             ready_i
);

  logic load_w;

  elastic_hs_ctl #(
    .GATE_LOAD(GATE_LOAD)
  ) u_ctl (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .valid_i(valid_i),
    .ready_i(ready_i),
    .ready_o(ready_o),
    .full_o (valid_o),
    .load_o (load_w)
  );

  elastic_dreg #(
    .WIDTH     (WIDTH),
    .CLEAR_DATA(CLEAR_DATA)
  ) u_dreg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(load_w),
    .d_i   (data_i),
    .q_o   (data_o)
  );

endmodule

// File: rtl/elastic_stage_chk.sv
module elastic_stage_chk #(
  parameter int WIDTH     = 8,
  parameter bit GATE_LOAD = 1'b1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             valid_i,
  input logic [WIDTH-1:0] data_i,
  input logic             ready_o,
  input logic             valid_o,
  input logic [WIDTH-1:0] data_o,
  input logic             ready_i
);

  assert_stall_blocks_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && !ready_i) |-> !ready_o);

  assert_empty_ready_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> ready_o);

  assert_accept_fills_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && ready_o) |=> (valid_o && data_o == $past(data_i)));

  assert_stall_holds_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  assert_drain_empties_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && ready_i && !valid_i) |=> !valid_o);

  assert_stream_stays_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && ready_i && valid_i) |=> valid_o);

  generate
    if (GATE_LOAD) begin : g_gate_chk
      assert_idle_no_load_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(valid_i && ready_o) |=> $stable(data_o));
    end else begin : g_free_chk
      assert_free_load_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> (data_o == $past(data_i)));
    end
  endgenerate

endmodule

bind elastic_stage elastic_stage_chk #(
  .WIDTH    (WIDTH),
  .GATE_LOAD(GATE_LOAD)
) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .valid_i(valid_i),
  .data_i (data_i),
  .ready_o(ready_o),
  .valid_o(valid_o),
  .data_o (data_o),
  .ready_i(ready_i)
);

// File: tb/sim_elastic_stage.sv
`timescale 1ns/1ps
module sim_elastic_stage;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_i = 1'b1;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ready_i = 1'b0;

  logic         rdy0, vld0, rdy1, vld1;
  logic [W-1:0] dat0, dat1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Default build: clearing reset, gated load.
  elastic_stage #(.WIDTH(W), .CLEAR_DATA(1'b1), .GATE_LOAD(1'b1)) u0 (
    .clk_i(clk), .rst_i(rst_i), .valid_i(valid_i), .data_i(data_i),
    .ready_o(rdy0), .valid_o(vld0), .data_o(dat0), .ready_i(ready_i));

  // Alternate build: no data reset, free-running load.
  elastic_stage #(.WIDTH(W), .CLEAR_DATA(1'b0), .GATE_LOAD(1'b0)) u1 (
    .clk_i(clk), .rst_i(rst_i), .valid_i(valid_i), .data_i(data_i),
    .ready_o(rdy1), .valid_o(vld1), .data_o(dat1), .ready_i(ready_i));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_i = 1'b1; valid_i = 1'b0; ready_i = 1'b0;
    step(); step();
    chk(vld0 == 1'b0, "R2 u0 valid after reset", vld0, 0);
    chk(vld1 == 1'b0, "R2 u1 valid after reset", vld1, 0);
    chk(dat0 == '0, "R7 data cleared", dat0, 0);
    rst_i = 1'b0;
    #1;
    chk(rdy0 == 1'b1, "R1 ready when empty", rdy0, 1);
  endtask

  task automatic t_fill_and_stall();
    valid_i = 1'b1; data_i = 8'hA5; ready_i = 1'b0;
    step();
    chk(vld0 == 1'b1, "R3 valid after accept", vld0, 1);
    chk(dat0 == 8'hA5, "R3 data after accept", dat0, 8'hA5);
    valid_i = 1'b1; data_i = 8'h3C;
    #1;
    chk(rdy0 == 1'b0, "R1 not ready when full and stalled", rdy0, 0);
    step(); step();
    chk(vld0 == 1'b1, "R4 valid held in stall", vld0, 1);
    chk(dat0 == 8'hA5, "R11 offered word not taken", dat0, 8'hA5);
    ready_i = 1'b1;
    #1;
    chk(rdy0 == 1'b1, "R1 ready when full and draining", rdy0, 1);
  endtask

  task automatic t_stream();
    ready_i = 1'b1; valid_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      data_i = 8'h10 + W'(k);
      step();
      chk(vld0 == 1'b1, "R6 valid stays while streaming", vld0, 1);
      chk(dat0 == 8'h10 + W'(k), "R6 data follows stream", dat0, 8'h10 + k);
    end
  endtask

  task automatic t_drain();
    valid_i = 1'b0; ready_i = 1'b1; data_i = 8'h55;
    step();
    chk(vld0 == 1'b0, "R5 empties on take", vld0, 0);
  endtask

  task automatic t_gating();
    valid_i = 1'b0; ready_i = 1'b0; data_i = 8'hEE;
    step();
    chk(dat0 == 8'h13, "R9 gated data unchanged", dat0, 8'h13);
    chk(dat1 == 8'hEE, "R10 free load takes data_i", dat1, 8'hEE);
    chk(vld1 == 1'b0, "R10 valid unaffected by free load", vld1, 0);
  endtask

  task automatic t_keep_on_reset();
    valid_i = 1'b1; data_i = 8'h77; ready_i = 1'b0;
    step();
    chk(dat1 == 8'h77, "R3 u1 loaded", dat1, 8'h77);
    valid_i = 1'b0; data_i = 8'h99; rst_i = 1'b1;
    step();
    chk(dat1 == 8'h77, "R8 data kept through reset", dat1, 8'h77);
    chk(vld1 == 1'b0, "R2 u1 valid cleared", vld1, 0);
    chk(dat0 == '0, "R7 data cleared again", dat0, 0);
    rst_i = 1'b0;
    step();
  endtask

  initial begin
    t_reset();
    t_fill_and_stall();
    t_stream();
    t_drain();
    t_gating();
    t_keep_on_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule